// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block sits in the always-on part of a small microcontroller core. It turns the raw external reset pin into a clean internal reset. The pin is sampled once per machine cycle at a fixed slot, and the internal reset asserts only after two consecutive samples read high. Pulses that are shorter than that have no effect. The internal reset is released only at a machine-cycle boundary.

The block divides the oscillator clock by two and uses the result to drive the clock-enable pulses for the CPU and for the peripherals. It holds the power control register and applies the idle and power-down modes through those enables and through the oscillator enable. A power-on flag in bit 4 of that register is set when the supply comes up. A warm reset leaves the flag unchanged, so software can tell a cold start from a pin reset.

A machine cycle is twelve oscillator periods, counted as slots 0 to 11. The reset pin is sampled in slot 9. The downstream logic uses `cpu_ce` and `per_ce` as clock enables on the oscillator clock, not as clocks.

Top module: `rpm_ctrl`

## Requirements
- R1: While `pwr_ok` is low, `int_rst` is 1 and `pcon_q` is 0x10, with the power-on flag in bit 4 set. After `pwr_ok` rises, `int_rst` stays high for exactly twelve oscillator edges, provided `rst_pin` is low.
- R2: Outside the two low-power modes, `cpu_ce` and `per_ce` each pulse on every second oscillator cycle. This gives six pulses per machine cycle, and no pulse lasts two consecutive cycles.
- R3: When `rst_pin` is high at the slot-9 sample of two consecutive machine cycles, `int_rst` asserts. It becomes visible at the start of slot 10 of the second of those cycles.
- R4: A high level on `rst_pin` that covers fewer than two sample points does not change `int_rst` or `pcon_q`. Both a 3-cycle glitch and a 12-cycle pulse fall in this case.
- R5: `int_rst` falls only at a machine-cycle boundary, where slot 0 begins, after a low sample of the pin.
- R6: While `int_rst` is high, `pcon_q` is cleared to zero except bit 4, which keeps its value whether that value is 0 or 1.
- R7: A write with `pcon_we` loads `pcon_wdata` into `pcon_q` on the next edge. Bit 4 can be set and cleared this way.
- R8: When bit 0 (idle) is set, `cpu_ce` stays low and `per_ce` keeps pulsing six times per machine cycle.
- R9: `irq_pend` while idle clears bit 0 on the next edge, and `cpu_ce` resumes.
- R10: When bit 1 (power-down) is set, `cpu_ce`, `per_ce` and `osc_en` are low. `irq_pend` does not clear bit 1.
- R11: In power-down, a high `rst_pin` raises `osc_en` after two synchronizer edges. The qualified reset that follows clears bit 1.
- R12: A write that sets bits 0 and 1 together stores bit 1 set and bit 0 clear, so power-down takes priority.
- R13: Writes are ignored while `int_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, always running in this domain |
| pwr_ok | input | 1 | Supply-good indication; low acts as synchronous active-low reset |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| irq_pend | input | 1 | An enabled interrupt is pending |
| pcon_we | input | 1 | Write strobe for the power control register |
| pcon_wdata | input | 8 | Write data for the power control register |
| cpu_ce | output | 1 | CPU clock-enable pulse |
| per_ce | output | 1 | Peripheral and interrupt clock-enable pulse |
| osc_en | output | 1 | Oscillator pad enable |
| int_rst | output | 1 | Qualified internal reset, active high |
| pcon_q | output | 8 | Power control register contents |

## Verification
The reset qualifier is driven with three pin patterns: a 3-cycle glitch, a pulse of exactly one machine cycle, and a hold of about two and a half machine cycles. The first two must leave `int_rst` untouched and the third must assert it. Together they separate a qualifier that counts sampled cycles from one that reacts to the level or counts only once. Release is timed against a machine-cycle boundary that the bench tracks from the power-good edge. The power register is exercised in four ways: writes of bit 4 both ways, the warm-reset clear with bit 4 at 0 and at 1, idle followed by an interrupt, and a combined idle and power-down write followed by interrupts and a pin reset. These cases tell apart which clock enable each mode gates and which events end each mode.

// File: rtl/rpm_pkg.sv
// Shared constants and types for the reset and power mode controller.
package rpm_pkg;

    localparam int PCON_W   = 8;
    localparam int BIT_IDLE = 0;   // software sets to enter idle
    localparam int BIT_PD   = 1;   // software sets to enter power-down
    localparam int BIT_POF  = 4;   // power-on flag, kept over warm reset

    localparam logic [PCON_W-1:0] POF_MASK = PCON_W'(1) << BIT_POF;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_PD   = 2'd2
    } pmode_e;

endpackage

// File: rtl/rpm_phase.sv
// Machine-cycle slot counter.
// Counts oscillator periods 0..SLOTS-1. Odd slots mark the second half of
// each internal (divided-by-two) clock period.
// Assumes SLOTS is even and that the counter runs even in power-down
// (always-on domain).
module rpm_phase #(
    parameter int SLOTS = 12,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk_osc,
    input  logic          pwr_ok,
    output logic [SW-1:0] slot,
    output logic          int_tick
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    // Advance the slot and wrap at the end of the machine cycle.
    always_ff @(posedge clk_osc) begin
        if (!pwr_ok)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    // One pulse per divided clock period.
    assign int_tick = slot[0];

endmodule

// File: rtl/rpm_rst_qual.sv
// External reset qualifier.
// Synchronises the pin, samples it once per machine cycle at SAMPLE, asserts
// the internal reset after REQ consecutive high samples, and releases it at
// the last slot following a low sample.
// Assumes SYNC >= 2, REQ >= 1 and SAMPLE < SLOTS-1.
module rpm_rst_qual #(
    parameter int SLOTS  = 12,
    parameter int SAMPLE = 9,
    parameter int REQ    = 2,
    parameter int SYNC   = 2,
    localparam int SW = $clog2(SLOTS),
    localparam int CW = $clog2(REQ + 1)
) (
    input  logic          clk_osc,
    input  logic          pwr_ok,
    input  logic          rst_pin,
    input  logic [SW-1:0] slot,
    output logic          rst_seen,
    output logic          int_rst
);

    localparam logic [SW-1:0] SAMP_S = SW'(SAMPLE);
    localparam logic [SW-1:0] LAST_S = SW'(SLOTS - 1);
    localparam logic [CW-1:0] REQ_C  = CW'(REQ);
    localparam logic [CW-1:0] REQ_M1 = CW'(REQ - 1);

    logic [SYNC-1:0] sync_q;
    logic [CW-1:0]   hi_cnt;
    logic            rel_pend;

    // Bring the asynchronous pin into the oscillator domain.
    always_ff @(posedge clk_osc) begin
        if (!pwr_ok)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC-2:0], rst_pin};
    end

    assign rst_seen = sync_q[SYNC-1];

    // Count sampled-high cycles; assert at the sample point, release at the boundary.
    always_ff @(posedge clk_osc) begin
        if (!pwr_ok) begin
            hi_cnt   <= '0;
            rel_pend <= 1'b0;
            int_rst  <= 1'b1;
        end else if (slot == SAMP_S) begin
            if (rst_seen) begin
                rel_pend <= 1'b0;
                if (hi_cnt < REQ_C)
                    hi_cnt <= hi_cnt + 1'b1;
                if (hi_cnt >= REQ_M1)
                    int_rst <= 1'b1;
            end else begin
                hi_cnt   <= '0;
                rel_pend <= int_rst;
            end
        end else if (slot == LAST_S && rel_pend) begin
            int_rst  <= 1'b0;
            rel_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rpm_pcon.sv
// Power control register and mode decode.
// Holds the register, applies write, warm-reset and interrupt-wake rules,
// and reports the current power mode. Power-down outranks idle.
module rpm_pcon
    import rpm_pkg::*;
(
    input  logic              clk_osc,
    input  logic              pwr_ok,
    input  logic              int_rst,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq_pend,
    output logic [PCON_W-1:0] pcon_q,
    output pmode_e            mode
);

    logic [PCON_W-1:0] wr_val;

    // Write value with power-down taking priority over idle.
    always_comb begin
        wr_val = pcon_wdata;
        if (pcon_wdata[BIT_PD])
            wr_val[BIT_IDLE] = 1'b0;
    end

    // Register update: cold reset, warm reset, write, idle wake.
    always_ff @(posedge clk_osc) begin
        if (!pwr_ok)
            pcon_q <= POF_MASK;
        else if (int_rst)
            pcon_q <= pcon_q & POF_MASK;
        else if (pcon_we)
            pcon_q <= wr_val;
        else if (irq_pend && pcon_q[BIT_IDLE])
            pcon_q[BIT_IDLE] <= 1'b0;
    end

    // Decode the mode from the register bits.
    always_comb begin
        if (pcon_q[BIT_PD])
            mode = MODE_PD;
        else if (pcon_q[BIT_IDLE])
            mode = MODE_IDLE;
        else
            mode = MODE_RUN;
    end

endmodule

// File: rtl/rpm_ctrl.sv
// Reset and power mode controller, top level.
// Joins the slot counter, the reset qualifier and the power register, and
// produces the clock enables and the oscillator enable.
// Assumes clk_osc keeps running in this domain; osc_en controls the pad.
module rpm_ctrl
    import rpm_pkg::*;
#(
    parameter int MC_SLOTS    = 12,
    parameter int SAMPLE_SLOT = 9,
    parameter int REQ_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_osc,
    input  logic              pwr_ok,
    input  logic              rst_pin,
    input  logic              irq_pend,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    output logic              cpu_ce,
    output logic              per_ce,
    output logic              osc_en,
    output logic              int_rst,
    output logic [PCON_W-1:0] pcon_q
);

    localparam int SW = $clog2(MC_SLOTS);

    logic [SW-1:0] slot;
    logic          int_tick;
    logic          rst_seen;
    pmode_e        mode;

    rpm_phase #(.SLOTS(MC_SLOTS)) u_phase (
        .clk_osc  (clk_osc),
        .pwr_ok   (pwr_ok),
        .slot     (slot),
        .int_tick (int_tick)
    );

    rpm_rst_qual #(
        .SLOTS  (MC_SLOTS),
        .SAMPLE (SAMPLE_SLOT),
        .REQ    (REQ_CYCLES),
        .SYNC   (SYNC_STAGES)
    ) u_qual (
        .clk_osc  (clk_osc),
        .pwr_ok   (pwr_ok),
        .rst_pin  (rst_pin),
        .slot     (slot),
        .rst_seen (rst_seen),
        .int_rst  (int_rst)
    );

    rpm_pcon u_pcon (
        .clk_osc    (clk_osc),
        .pwr_ok     (pwr_ok),
        .int_rst    (int_rst),
        .pcon_we    (pcon_we),
        .pcon_wdata (pcon_wdata),
        .irq_pend   (irq_pend),
        .pcon_q     (pcon_q),
        .mode       (mode)
    );

    // Gate the divided tick by mode; a seen reset pin wakes the oscillator.
    always_comb begin
        cpu_ce = int_tick && (mode == MODE_RUN);
        per_ce = int_tick && (mode != MODE_PD);
        osc_en = (mode != MODE_PD) || rst_seen;
    end

endmodule

// File: rtl/rpm_ctrl_chk.sv
// Temporal checks on the reset and power mode controller, bound to the top.
module rpm_ctrl_chk #(
    parameter int SLOTS  = 12,
    parameter int SAMPLE = 9,
    localparam int SW = $clog2(SLOTS)
) (
    input logic          clk_osc,
    input logic          pwr_ok,
    input logic          irq_pend,
    input logic          pcon_we,
    input logic [7:0]    pcon_wdata,
    input logic          cpu_ce,
    input logic          per_ce,
    input logic          osc_en,
    input logic          int_rst,
    input logic [7:0]    pcon_q,
    input logic [SW-1:0] slot
);

    // R3
    rst_on_sample_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        $rose(int_rst) |-> slot == SW'((SAMPLE + 1) % SLOTS));

    // R5
    rel_at_boundary_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        $fell(int_rst) |-> slot == '0);

    // R6
    warm_clear_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        int_rst |=> ((pcon_q & 8'hEF) == 8'h00) && $stable(pcon_q[4]));

    // R9
    idle_wake_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        (pcon_q[0] && irq_pend && !pcon_we && !int_rst) |=> !pcon_q[0]);

    // R10
    pd_hold_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        (pcon_q[1] && !int_rst && !pcon_we) |=> pcon_q[1]);

    // R10
    osc_off_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        !osc_en |-> (!cpu_ce && !per_ce));

    // R12
    pd_prio_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        (pcon_we && pcon_wdata[1] && !int_rst) |=> (pcon_q[1] && !pcon_q[0]));

    // R2
    tick_alt_chk: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
        per_ce |=> !per_ce);

endmodule

bind rpm_ctrl rpm_ctrl_chk #(.SLOTS(MC_SLOTS), .SAMPLE(SAMPLE_SLOT)) u_chk (
    .clk_osc    (clk_osc),
    .pwr_ok     (pwr_ok),
    .irq_pend   (irq_pend),
    .pcon_we    (pcon_we),
    .pcon_wdata (pcon_wdata),
    .cpu_ce     (cpu_ce),
    .per_ce     (per_ce),
    .osc_en     (osc_en),
    .int_rst    (int_rst),
    .pcon_q     (pcon_q),
    .slot       (slot)
);

// File: tb/rpm_ctrl_tb.sv
module rpm_ctrl_tb;

    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       rst_pin = 1'b0;
    logic       irq_pend = 1'b0;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = 8'h00;
    logic       cpu_ce, per_ce, osc_en, int_rst;
    logic [7:0] pcon_q;

    int checks = 0;
    int errors = 0;
    int bslot = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rpm_ctrl u_dut (
        .clk_osc    (clk),
        .pwr_ok     (pwr_ok),
        .rst_pin    (rst_pin),
        .irq_pend   (irq_pend),
        .pcon_we    (pcon_we),
        .pcon_wdata (pcon_wdata),
        .cpu_ce     (cpu_ce),
        .per_ce     (per_ce),
        .osc_en     (osc_en),
        .int_rst    (int_rst),
        .pcon_q     (pcon_q)
    );

    // Bench view of the machine-cycle slot: 12 periods from power-good.
    always @(posedge clk) begin
        if (!pwr_ok) bslot <= 0;
        else bslot <= (bslot == 11) ? 0 : bslot + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic count_ce(input int n, output int nc, output int np, output int dbl);
        bit prev = 1'b0;
        nc = 0; np = 0; dbl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nc += int'(cpu_ce);
            np += int'(per_ce);
            if (prev && per_ce) dbl++;
            prev = per_ce;
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        pcon_we = 1'b1;
        pcon_wdata = v;
        @(negedge clk);
        pcon_we = 1'b0;
    endtask

    task automatic wait_release(input string req);
        int n = 0;
        while (int_rst && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(!int_rst, req, int'(int_rst), 0);
        chk(bslot == 0, req, bslot, 0);
    endtask

    task automatic t_power_on;
        repeat (3) @(negedge clk);
        chk(int_rst == 1'b1, "R1", int'(int_rst), 1);
        chk(pcon_q == 8'h10, "R1", pcon_q, 8'h10);
        pwr_ok = 1'b1;
        repeat (11) @(negedge clk);
        chk(int_rst == 1'b1, "R1", int'(int_rst), 1);
        @(negedge clk);
        chk(int_rst == 1'b0, "R1", int'(int_rst), 0);
    endtask

    task automatic t_run_enables;
        int nc, np, dbl;
        count_ce(12, nc, np, dbl);
        chk(nc == 6, "R2", nc, 6);
        chk(np == 6, "R2", np, 6);
        chk(dbl == 0, "R2", dbl, 0);
    endtask

    task automatic t_write;
        wr(8'hE0);
        chk(pcon_q == 8'hE0, "R7", pcon_q, 8'hE0);
        wr(8'h10);
        chk(pcon_q == 8'h10, "R7", pcon_q, 8'h10);
    endtask

    task automatic t_glitch;
        int hits = 0;
        wr(8'h24);
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (3) @(negedge clk);
        rst_pin = 1'b0;
        repeat (20) begin @(negedge clk); hits += int'(int_rst); end
        rst_pin = 1'b1;
        repeat (12) begin @(negedge clk); hits += int'(int_rst); end
        rst_pin = 1'b0;
        repeat (30) begin @(negedge clk); hits += int'(int_rst); end
        chk(hits == 0, "R4", hits, 0);
        chk(pcon_q == 8'h24, "R4", pcon_q, 8'h24);
    endtask

    task automatic t_ext_reset;
        wr(8'hF4);
        rst_pin = 1'b1;
        repeat (30) @(negedge clk);
        chk(int_rst == 1'b1, "R3", int'(int_rst), 1);
        chk(pcon_q == 8'h10, "R6", pcon_q, 8'h10);
        wr(8'h21);
        chk(pcon_q == 8'h10, "R13", pcon_q, 8'h10);
        rst_pin = 1'b0;
        wait_release("R5");
        wr(8'h04);
        rst_pin = 1'b1;
        repeat (30) @(negedge clk);
        chk(pcon_q == 8'h00, "R6", pcon_q, 8'h00);
        rst_pin = 1'b0;
        wait_release("R5");
    endtask

    task automatic t_idle;
        int nc, np, dbl;
        wr(8'h01);
        count_ce(12, nc, np, dbl);
        chk(nc == 0, "R8", nc, 0);
        chk(np == 6, "R8", np, 6);
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        chk(pcon_q[0] == 1'b0, "R9", int'(pcon_q[0]), 0);
        count_ce(12, nc, np, dbl);
        chk(nc == 6, "R9", nc, 6);
    endtask

    task automatic t_power_down;
        int nc, np, dbl;
        wr(8'h03);
        chk(pcon_q == 8'h02, "R12", pcon_q, 8'h02);
        chk(osc_en == 1'b0, "R10", int'(osc_en), 0);
        count_ce(12, nc, np, dbl);
        chk(nc + np == 0, "R10", nc + np, 0);
        irq_pend = 1'b1;
        repeat (3) @(negedge clk);
        irq_pend = 1'b0;
        chk(pcon_q == 8'h02, "R10", pcon_q, 8'h02);
        rst_pin = 1'b1;
        @(negedge clk);
        chk(osc_en == 1'b0, "R11", int'(osc_en), 0);
        @(negedge clk);
        chk(osc_en == 1'b1, "R11", int'(osc_en), 1);
        repeat (28) @(negedge clk);
        chk(int_rst == 1'b1, "R11", int'(int_rst), 1);
        chk(pcon_q == 8'h00, "R11", pcon_q, 8'h00);
        rst_pin = 1'b0;
        wait_release("R5");
        count_ce(12, nc, np, dbl);
        chk(nc == 6, "R11", nc, 6);
    endtask

    initial begin
        t_power_on();
        t_run_enables();
        t_write();
        t_glitch();
        t_ext_reset();
        t_idle();
        t_power_down();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0x0 expected 0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule